// File: doc/BRIEF.md
# Virtual Supervisor Top-Interrupt Selector

This block chooses which interrupt a guest running in virtual-supervisor mode should see as its most urgent one. It then reports that interrupt as a packed identity/priority word, registered once. It looks at three possible candidates:

- an external interrupt supplied from outside, with its own priority number;
- a hypervisor-injected interrupt, whose identity and priority come from the virtual interrupt control fields;
- the best major interrupt that is both pending and enabled in the guest's pending and enable vectors.

The hypervisor's injection switch decides whether the injected interrupt or the best major interrupt competes with the external candidate. A lower priority number wins. When two priority numbers are equal, the tie is settled by a fixed code order, or by a single direction bit when an injected interrupt with an identity other than the external code is involved. A mode bit selects whether the reported priority is the real, clamped priority number or the constant 1.

Trap logic samples the word every cycle. A non-zero word, with the valid flag set, means that some interrupt is deliverable to the guest.

Top module: `vstopi_sel`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `top_word` is zero and `top_vld` is low.
- R2: The output is registered, so inputs seen at one rising edge show up after that edge. When there is no external candidate, `vti` is 0, and no code other than 9 is both pending and enabled, `top_vld` is 0 and `top_word` is 0.
- R3: With `vti` = 0, the major candidate is taken only from codes 0 to N_IRQ-1 whose bits are set in both `vs_pend` and `vs_en`. Code 9 is never chosen, whatever its priority.
- R4: The priority number of code c is byte c of `prio_lo` (bits 8c+7:8c) for c < 8, and byte c-8 of `prio_hi` for 8 ≤ c < 16. Codes 16 and above have priority 0. A lower number is a higher priority.
- R5: With `vti` = 0, equal major priorities go to the lower code. The external candidate has identity 9, so on a tie it loses to major codes below 9 and beats major codes above 9. `ext_vld` asserts that the external interrupt is already pending and enabled.
- R6: With `vti` = 1, the injected candidate (identity `iid`, priority `inj_prio`) replaces the major candidate, and `vs_pend`/`vs_en` have no effect. If `iid` = 9, the lower priority number between the external and injected candidates wins.
- R7: With `vti` = 1, `iid` ≠ 9, and equal priorities against the external candidate, the injected candidate wins when `dpr` = 0 and the external candidate wins when `dpr` = 1.
- R8: With `iprio_mode` = 0, the reported priority field is 1 whenever a candidate is selected.
- R9: With `iprio_mode` = 1, the reported priority follows the winner's priority number: a number in 1..255 is reported unchanged, 0 reports 0, and a number above 255 (possible only for the 11-bit `ext_prio`) reports 255.
- R10: `top_word` carries the winner's identity in bits 27:16 and the reported priority in bits 7:0. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_pend | input | N_IRQ | Guest pending vector, one bit per code |
| vs_en | input | N_IRQ | Guest enable vector, one bit per code |
| vti | input | 1 | Injection switch: 1 selects the injected candidate |
| iid | input | 12 | Identity of the injected interrupt |
| dpr | input | 1 | Tie direction for the injected interrupt (0 = injected wins) |
| inj_prio | input | 8 | Priority number of the injected interrupt |
| iprio_mode | input | 1 | 1 = report the real priority, 0 = report 1 |
| prio_lo | input | 64 | Priority bytes for codes 0 to 7 |
| prio_hi | input | 64 | Priority bytes for codes 8 to 15 |
| ext_vld | input | 1 | External candidate present |
| ext_prio | input | 11 | External candidate priority number |
| top_word | output | 32 | Packed identity/priority word |
| top_vld | output | 1 | A candidate was selected |

## Verification
A wrong choice inside the picker or the pair arbiter appears in the identity field one clock after the inputs that expose it. A broken tie rule needs equal priority numbers to show up at all, so the tie paths are driven on purpose: lower code, external against low and high codes, and both `dpr` values. A fault in the clamping or in the mode handling shows only in bits 7:0, and only for priority numbers of 0, of 255, or above 255. A random sweep with few distinct priority values makes ties frequent, so a latent fault shows within a few dozen vectors.

// File: rtl/vti_pkg.sv
package vti_pkg;

    localparam int ID_W       = 12;
    localparam int PRIO_X_W   = 9;
    localparam int EXT_PRIO_W = 11;
    localparam int WORD_W     = 32;
    localparam int ID_LSB     = 16;
    localparam int SEI_CODE   = 9;
    localparam int BYTES_PER_REG = 8;
    localparam int COVERED    = 2 * BYTES_PER_REG;

    typedef struct packed {
        logic                vld;
        logic [ID_W-1:0]     id;
        logic [PRIO_X_W-1:0] prio;
    } cand_t;

    // Saturate a wide priority into the 9-bit extended form (256 = above range).
    function automatic logic [PRIO_X_W-1:0] sat_prio(input logic [EXT_PRIO_W-1:0] p);
        if (p > EXT_PRIO_W'(255))
            return PRIO_X_W'(256);
        return {1'b0, p[7:0]};
    endfunction

    function automatic logic [7:0] report_prio(input logic mode,
                                               input logic [PRIO_X_W-1:0] p);
        if (!mode)
            return 8'd1;
        if (p == '0)
            return 8'd0;
        if (p > PRIO_X_W'(255))
            return 8'd255;
        return p[7:0];
    endfunction

endpackage

// File: rtl/vti_major_pick.sv
module vti_major_pick
    import vti_pkg::*;
#(
    parameter int N_IRQ = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N_IRQ-1:0] pend,
    input  logic [N_IRQ-1:0] en,
    input  logic [63:0]      prio_lo,
    input  logic [63:0]      prio_hi,
    output cand_t            best
);
    localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

    logic [7:0]       code_prio [N_IRQ];
    logic [N_IRQ-1:0] live;

    assign live = pend & en;

    generate
        for (genvar g = 0; g < N_IRQ; g++) begin : g_prio
            if (g < BYTES_PER_REG) begin : g_lo
                assign code_prio[g] = prio_lo[8*g +: 8];
            end else if (g < COVERED) begin : g_hi
                assign code_prio[g] = prio_hi[8*(g-BYTES_PER_REG) +: 8];
            end else begin : g_none
                assign code_prio[g] = 8'd0;
            end
        end
    endgenerate

    // Ascending scan with strict compare: equal priorities keep the lower code.
    always_comb begin
        best = '0;
        for (int i = 0; i < N_IRQ; i++) begin
            if (live[i] && (i != SEI_CODE) &&
                (!best.vld || ({1'b0, code_prio[i]} < best.prio))) begin
                best.vld  = 1'b1;
                best.id   = ID_W'(i);
                best.prio = {1'b0, code_prio[i]};
            end
        end
    end

    p_no_sei_major_r3: assert property (@(posedge clk) disable iff (rst)
        best.vld |-> best.id != ID_W'(SEI_CODE));

    p_pick_live_r3: assert property (@(posedge clk) disable iff (rst)
        best.vld |-> live[best.id[IDX_W-1:0]]);

    p_uncovered_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (best.vld && best.id >= ID_W'(COVERED)) |-> best.prio == '0);

endmodule

// File: rtl/vti_pair_arb.sv
module vti_pair_arb
    import vti_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t a,
    input  cand_t b,
    input  logic  b_wins_tie,
    output cand_t win
);
    always_comb begin
        if (!b.vld)
            win = a;
        else if (!a.vld)
            win = b;
        else if (b.prio < a.prio)
            win = b;
        else if ((b.prio == a.prio) && b_wins_tie)
            win = b;
        else
            win = a;
    end

    p_best_prio_r5: assert property (@(posedge clk) disable iff (rst)
        win.vld |-> ((!a.vld || win.prio <= a.prio) && (!b.vld || win.prio <= b.prio)));

    p_any_valid_r2: assert property (@(posedge clk) disable iff (rst)
        win.vld == (a.vld || b.vld));

endmodule

// File: rtl/vti_word_fmt.sv
module vti_word_fmt
    import vti_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cand_t             win,
    input  logic              mode,
    output logic [WORD_W-1:0] word
);
    logic [7:0] rep;

    assign rep = report_prio(mode, win.prio);

    always_comb begin
        word = '0;
        if (win.vld) begin
            word[ID_LSB +: ID_W] = win.id;
            word[7:0]            = rep;
        end
    end

    p_clamp_hi_r9: assert property (@(posedge clk) disable iff (rst)
        (win.vld && mode && win.prio > PRIO_X_W'(255)) |-> word[7:0] == 8'd255);

    p_zero_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (win.vld && mode && win.prio == '0) |-> word[7:0] == 8'd0);

endmodule

// File: rtl/vstopi_sel.sv
module vstopi_sel
    import vti_pkg::*;
#(
    parameter int N_IRQ = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IRQ-1:0]  vs_pend,
    input  logic [N_IRQ-1:0]  vs_en,
    input  logic              vti,
    input  logic [11:0]       iid,
    input  logic              dpr,
    input  logic [7:0]        inj_prio,
    input  logic              iprio_mode,
    input  logic [63:0]       prio_lo,
    input  logic [63:0]       prio_hi,
    input  logic              ext_vld,
    input  logic [10:0]       ext_prio,
    output logic [31:0]       top_word,
    output logic              top_vld
);
    cand_t maj_c, inj_c, ext_c, alt_c, win_c;
    logic  b_tie;
    logic [WORD_W-1:0] nxt_word;

    vti_major_pick #(.N_IRQ(N_IRQ)) u_pick (
        .clk     (clk),
        .rst     (rst),
        .pend    (vs_pend),
        .en      (vs_en),
        .prio_lo (prio_lo),
        .prio_hi (prio_hi),
        .best    (maj_c)
    );

    always_comb begin
        ext_c.vld  = ext_vld;
        ext_c.id   = ID_W'(SEI_CODE);
        ext_c.prio = sat_prio(ext_prio);

        inj_c.vld  = vti;
        inj_c.id   = iid;
        inj_c.prio = {1'b0, inj_prio};

        alt_c = vti ? inj_c : maj_c;

        // Tie direction: code order normally, the single direction bit for a
        // non-external injected identity.
        if (vti)
            b_tie = (iid != ID_W'(SEI_CODE)) && !dpr;
        else
            b_tie = maj_c.id < ID_W'(SEI_CODE);
    end

    vti_pair_arb u_arb (
        .clk        (clk),
        .rst        (rst),
        .a          (ext_c),
        .b          (alt_c),
        .b_wins_tie (b_tie),
        .win        (win_c)
    );

    vti_word_fmt u_fmt (
        .clk  (clk),
        .rst  (rst),
        .win  (win_c),
        .mode (iprio_mode),
        .word (nxt_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            top_word <= '0;
            top_vld  <= 1'b0;
        end else begin
            top_word <= nxt_word;
            top_vld  <= win_c.vld;
        end
    end

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !top_vld |-> top_word == '0);

    p_layout_r10: assert property (@(posedge clk) disable iff (rst)
        top_word[31:28] == 4'd0 && top_word[15:8] == 8'd0);

    p_mode_one_r8: assert property (@(posedge clk) disable iff (rst)
        (top_vld && !$past(iprio_mode)) |-> top_word[7:0] == 8'd1);

    p_dpr_tie_r7: assert property (@(posedge clk) disable iff (rst)
        (vti && ext_vld && iid != ID_W'(SEI_CODE) && ext_c.prio == inj_c.prio)
        |-> win_c.id == (dpr ? ID_W'(SEI_CODE) : iid));

endmodule

// File: tb/vstopi_sel_test.sv
module vstopi_sel_test;
    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst;
    logic [N-1:0] vs_pend, vs_en;
    logic        vti, dpr, iprio_mode, ext_vld;
    logic [11:0] iid;
    logic [7:0]  inj_prio;
    logic [63:0] prio_lo, prio_hi;
    logic [10:0] ext_prio;
    logic [31:0] top_word;
    logic        top_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [31:0] rng = 32'h1357_9BDF;

    always #10 clk = ~clk;

    vstopi_sel #(.N_IRQ(N)) uut (
        .clk(clk), .rst(rst), .vs_pend(vs_pend), .vs_en(vs_en), .vti(vti),
        .iid(iid), .dpr(dpr), .inj_prio(inj_prio), .iprio_mode(iprio_mode),
        .prio_lo(prio_lo), .prio_hi(prio_hi), .ext_vld(ext_vld),
        .ext_prio(ext_prio), .top_word(top_word), .top_vld(top_vld)
    );

    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y = x;
        y ^= y << 13;
        y ^= y >> 17;
        y ^= y << 5;
        return y;
    endfunction

    // Reference built from the requirement text.
    function automatic logic [32:0] model();
        int  bid = 0, bp = 0, ap, aid, ep, wp, wid;
        bit  bv = 0, av, wv, tie_alt;
        logic [7:0] rep;
        logic [31:0] w;
        for (int c = 0; c < N; c++) begin
            int p;
            p = (c < 8) ? int'(prio_lo[8*c +: 8]) :
                (c < 16) ? int'(prio_hi[8*(c-8) +: 8]) : 0;
            if (vs_pend[c] && vs_en[c] && c != 9 && (!bv || p < bp)) begin
                bv = 1; bid = c; bp = p;
            end
        end
        av  = vti ? 1'b1 : bv;
        aid = vti ? int'(iid) : bid;
        ap  = vti ? int'(inj_prio) : bp;
        ep  = (ext_prio > 255) ? 256 : int'(ext_prio);
        tie_alt = vti ? (iid != 9 && !dpr) : (bid < 9);
        wv = av || ext_vld;
        if (!ext_vld)         begin wid = aid; wp = ap; end
        else if (!av)         begin wid = 9;   wp = ep; end
        else if (ap < ep || (ap == ep && tie_alt)) begin wid = aid; wp = ap; end
        else                  begin wid = 9;   wp = ep; end
        if (!iprio_mode) rep = 8'd1;
        else if (wp == 0) rep = 8'd0;
        else if (wp > 255) rep = 8'd255;
        else rep = wp[7:0];
        w = wv ? {4'd0, wid[11:0], 8'd0, rep} : 32'd0;
        return {wv, w};
    endfunction

    task automatic check(input string req, input logic [31:0] ew, input logic ev);
        n_cmp++;
        if (top_word !== ew || top_vld !== ev) begin
            n_bad++;
            $display("FAIL %s: word=%h vld=%b expected word=%h vld=%b",
                     req, top_word, top_vld, ew, ev);
        end
    endtask

    task automatic clear();
        vs_pend = '0; vs_en = '0; vti = 0; dpr = 0; iid = '0; inj_prio = '0;
        iprio_mode = 1; prio_lo = '0; prio_hi = '0; ext_vld = 0; ext_prio = '0;
    endtask

    // Inputs were set after a falling edge; capture on the rising edge, then
    // sample at the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        clear();
        rst = 1;
        vs_pend = '1; vs_en = '1; ext_vld = 1;
        repeat (3) @(negedge clk);
        check("R1 in reset", 32'h0, 1'b0);
        rst = 0;
        clear();
        @(negedge clk);
        check("R1 after release", 32'h0, 1'b0);
    endtask

    task automatic t_idle();
        clear();
        vs_pend[9] = 1; vs_en[9] = 1; vs_pend[4] = 1;
        step();
        check("R2 nothing selectable", 32'h0, 1'b0);
    endtask

    task automatic t_major();
        clear();
        iprio_mode = 0;
        vs_pend[3] = 1; vs_pend[5] = 1; vs_en[5] = 1;
        step();
        check("R3 enabled only", 32'h0005_0001, 1'b1);
        clear();
        vs_pend[3] = 1; vs_en[3] = 1; vs_pend[9] = 1; vs_en[9] = 1;
        prio_lo[8*3 +: 8] = 8'd200;
        step();
        check("R3 code 9 excluded", 32'h0003_00C8, 1'b1);
    endtask

    task automatic t_prio_map();
        clear();
        vs_pend[2] = 1; vs_en[2] = 1; vs_pend[12] = 1; vs_en[12] = 1;
        prio_lo = 64'h0000_0000_0028_0000;
        prio_hi = 64'h0000_000A_0000_0000;
        step();
        check("R4 hi byte wins", 32'h000C_000A, 1'b1);
        clear();
        vs_pend[2] = 1; vs_en[2] = 1; vs_pend[20] = 1; vs_en[20] = 1;
        prio_lo = 64'h0000_0000_0005_0000;
        step();
        check("R4 uncovered code prio 0", 32'h0014_0000, 1'b1);
    endtask

    task automatic t_ties_default();
        clear();
        vs_pend[4] = 1; vs_en[4] = 1; vs_pend[7] = 1; vs_en[7] = 1;
        prio_lo = 64'h1E00_001E_0000_0000;
        step();
        check("R5 lower code wins", 32'h0004_001E, 1'b1);
        clear();
        vs_pend[7] = 1; vs_en[7] = 1; prio_lo = 64'h1E00_0000_0000_0000;
        ext_vld = 1; ext_prio = 11'd30;
        step();
        check("R5 code 7 beats ext", 32'h0007_001E, 1'b1);
        clear();
        vs_pend[11] = 1; vs_en[11] = 1; prio_hi = 64'h0000_0000_1E00_0000;
        ext_vld = 1; ext_prio = 11'd30;
        step();
        check("R5 ext beats code 11", 32'h0009_001E, 1'b1);
    endtask

    task automatic t_inject();
        clear();
        vti = 1; iid = 12'd9; inj_prio = 8'd50; ext_vld = 1; ext_prio = 11'd20;
        vs_pend[1] = 1; vs_en[1] = 1;
        step();
        check("R6 ext lower number", 32'h0009_0014, 1'b1);
        ext_prio = 11'd60;
        step();
        check("R6 injected lower number", 32'h0009_0032, 1'b1);
        ext_vld = 0; iid = 12'h123; inj_prio = 8'd7;
        step();
        check("R6 pend vector ignored", 32'h0123_0007, 1'b1);
    endtask

    task automatic t_dpr();
        clear();
        vti = 1; iid = 12'h123; inj_prio = 8'd40; ext_vld = 1; ext_prio = 11'd40;
        dpr = 0;
        step();
        check("R7 dpr=0 injected", 32'h0123_0028, 1'b1);
        dpr = 1;
        step();
        check("R7 dpr=1 external", 32'h0009_0028, 1'b1);
    endtask

    task automatic t_report();
        clear();
        ext_vld = 1; ext_prio = 11'd300; iprio_mode = 0;
        step();
        check("R8 mode 0 reports 1", 32'h0009_0001, 1'b1);
        iprio_mode = 1;
        step();
        check("R9 above range", 32'h0009_00FF, 1'b1);
        ext_prio = 11'd256;
        step();
        check("R9 256", 32'h0009_00FF, 1'b1);
        ext_prio = 11'd255;
        step();
        check("R9 255", 32'h0009_00FF, 1'b1);
        ext_prio = 11'd0;
        step();
        check("R9 zero", 32'h0009_0000, 1'b1);
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 400; i++) begin
            logic [32:0] e;
            clear();
            rng = next_rng(rng); vs_pend = rng[N-1:0];
            rng = next_rng(rng); vs_en = rng[N-1:0];
            for (int b = 0; b < 8; b++) begin
                rng = next_rng(rng);
                prio_lo[8*b +: 8] = 8'(rng[1:0] * 3);
                prio_hi[8*b +: 8] = 8'(rng[3:2] * 3);
            end
            rng = next_rng(rng);
            ext_vld    = rng[0];
            ext_prio   = (rng[7:5] == 3'd7) ? 11'd700 : 11'(rng[2:1] * 3);
            iprio_mode = rng[3];
            inj_prio   = 8'(rng[10:9] * 3);
            case (i % 4)
                0: vti = 0;
                1: begin vti = 1; iid = 12'd9; end
                2: begin vti = 1; iid = 12'(rng[20:12] | 9'h100); dpr = 0; end
                default: begin vti = 1; iid = 12'(rng[20:12] | 9'h100); dpr = 1; end
            endcase
            e = model();
            step();
            check("R7 R5 R9 sweep", e[31:0], e[32]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1;
        clear();
        @(negedge clk);
        t_reset();
        t_idle();
        t_major();
        t_prio_map();
        t_ties_default();
        t_inject();
        t_dpr();
        t_report();
        t_sweep();
        // R10: layout is covered by every exact word compared above.
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule